// File: doc/BRIEF.md
# Set/Clear GPIO Register Bank

This block is the software-visible register file of a 32-pin general-purpose I/O port. It holds a drive-level register and a direction register. Each of the two can be written in three ways: a plain overwrite, a write-one-to-set form and a write-one-to-clear form. Every pin also owns a 32-bit configuration word. A read-only input register shows the pin levels that a separate resolution block supplies. The contents of every register also leave the bank on parallel outputs, so that the resolution block can act on them.

Each pin's direction bit is held once but can be seen in two places: in the port-wide direction register and in bit 0 of that pin's configuration word. A write through either view updates both, so the two can never disagree. The bus is a simple single-cycle interface. Read data is combinational from the address. A write takes effect at the clock edge on which `bus_wr` is sampled. Only aligned 32-bit words are decoded. An access to any other address returns zero, changes nothing, and raises a one-cycle error flag.

Top module: `gpio_setclr_bank`

## Requirements
- R1: After reset, reads of the drive-level, direction and input registers return 0, and every configuration word (bus read and `cfg_q`) equals 0x00000002.
- R2: A write to address 0x004 replaces the drive-level register with the write data.
- R3: A write to address 0x008 ORs the write data into the drive-level register.
- R4: A write to address 0x00C clears each drive-level bit that is 1 in the write data and leaves the other bits unchanged.
- R5: Reads of 0x004, 0x008 and 0x00C all return the drive-level register. Reads of 0x014, 0x018 and 0x01C all return the direction register.
- R6: Writes to 0x014 (replace), 0x018 (OR) and 0x01C (clear where 1) update the direction register. After any of them, bit 0 of pin i's configuration word equals direction bit i for every pin.
- R7: Pin i's configuration word is at 0x200 + 4*i (i = 0..31). A write there stores all 32 bits and sets direction bit i to write-data bit 0. No other pin's configuration word or direction bit changes.
- R8: A read of 0x010 returns `pin_in` as sampled on the previous clock edge. A write to 0x010 changes no register.
- R9: A read of an unmapped or misaligned address (any address with bits [1:0] non-zero) returns 0. A write to such an address changes no register.
- R10: `bad_addr` is high in the cycle after a clock edge that sampled `bus_rd` or `bus_wr` with an unmapped address. It is low in the cycle after any other edge.
- R11: `out_q`, `dir_q` and `cfg_q` (pin i in bits [32*i+31:32*i]) show the register contents from the cycle after the write edge onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 12 | Byte address |
| bus_rd | input | 1 | Read strobe (used only for error reporting) |
| bus_wr | input | 1 | Write enable |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for `bus_addr` |
| pin_in | input | 32 | Resolved pin input levels |
| out_q | output | 32 | Drive-level register |
| dir_q | output | 32 | Direction register |
| cfg_q | output | 1024 | All configuration words, pin i at bits 32*i+31:32*i |
| bad_addr | output | 1 | One-cycle flag for an access to an unmapped address |

## Verification
The drive-level and direction registers each receive overlapping patterns through the replace, set and clear forms. Only these overlaps separate OR and AND-NOT from a plain overwrite. Every direction update is followed by a check of bit 0 in all 32 configuration words, and every configuration write by a check of the single matching direction bit, with odd and even values on both high and low pins. This catches a mirror that copies in only one direction or hits the wrong index. Unmapped, misaligned and just-past-the-end addresses are read and written to show zero data, unchanged state and the error pulse. The error pulse is also checked to drop after a following mapped access.

// File: rtl/gpio_setclr_bank.sv
`timescale 1ns/1ps
module gpio_setclr_bank #(
  parameter int ADDR_W = 12,
  parameter logic [ADDR_W-1:0] CFG_BASE = 'h200
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic                bus_rd,
  input  logic                bus_wr,
  input  logic [31:0]         bus_wdata,
  output logic [31:0]         bus_rdata,
  input  logic [31:0]         pin_in,
  output logic [31:0]         out_q,
  output logic [31:0]         dir_q,
  output logic [32*32-1:0]    cfg_q,
  output logic                bad_addr
);
  localparam int NPINS = 32;
  localparam int DW    = 32;
  localparam int IDX_W = $clog2(NPINS);
  localparam logic [ADDR_W-1:0] A_OUT  = 'h004;
  localparam logic [ADDR_W-1:0] A_OSET = 'h008;
  localparam logic [ADDR_W-1:0] A_OCLR = 'h00C;
  localparam logic [ADDR_W-1:0] A_IN   = 'h010;
  localparam logic [ADDR_W-1:0] A_DIR  = 'h014;
  localparam logic [ADDR_W-1:0] A_DSET = 'h018;
  localparam logic [ADDR_W-1:0] A_DCLR = 'h01C;
  localparam logic [ADDR_W-1:0] CFG_SPAN = ADDR_W'(NPINS * 4);

  logic [NPINS-1:0] out_r, dir_r, in_r;
  logic [DW-1:1]    cfg_hi [NPINS];

  logic [ADDR_W-1:0] cfg_off;
  logic              cfg_hit, hit;
  logic [IDX_W-1:0]  cfg_idx;
  logic [DW-1:0]     rdata;

  assign cfg_off = bus_addr - CFG_BASE;
  assign cfg_hit = (bus_addr >= CFG_BASE) && (cfg_off < CFG_SPAN) && (bus_addr[1:0] == 2'b00);
  assign cfg_idx = cfg_off[IDX_W+1:2];

  always_comb begin
    rdata = '0;
    hit   = 1'b1;
    if (cfg_hit) begin
      rdata = {cfg_hi[cfg_idx], dir_r[cfg_idx]};
    end else begin
      case (bus_addr)
        A_OUT, A_OSET, A_OCLR: rdata = out_r;
        A_IN:                  rdata = in_r;
        A_DIR, A_DSET, A_DCLR: rdata = dir_r;
        default:               hit   = 1'b0;
      endcase
    end
  end

  assign bus_rdata = rdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_r    <= '0;
      dir_r    <= '0;
      in_r     <= '0;
      bad_addr <= 1'b0;
      for (int i = 0; i < NPINS; i++) cfg_hi[i] <= (DW-1)'(1);
    end else begin
      in_r     <= pin_in;
      bad_addr <= (bus_rd | bus_wr) & ~hit;
      if (bus_wr) begin
        if (cfg_hit) begin
          cfg_hi[cfg_idx] <= bus_wdata[DW-1:1];
          dir_r[cfg_idx]  <= bus_wdata[0];
        end else begin
          case (bus_addr)
            A_OUT:   out_r <= bus_wdata;
            A_OSET:  out_r <= out_r | bus_wdata;
            A_OCLR:  out_r <= out_r & ~bus_wdata;
            A_DIR:   dir_r <= bus_wdata;
            A_DSET:  dir_r <= dir_r | bus_wdata;
            A_DCLR:  dir_r <= dir_r & ~bus_wdata;
            default: ;
          endcase
        end
      end
    end
  end

  assign out_q = out_r;
  assign dir_q = dir_r;

  for (genvar g = 0; g < NPINS; g++) begin : g_cfg
    assign cfg_q[g*DW +: DW] = {cfg_hi[g], dir_r[g]};
  end
endmodule

// File: rtl/gpio_setclr_bank_chk.sv
`timescale 1ns/1ps
module gpio_setclr_bank_chk (
  input logic          clk,
  input logic          rst_n,
  input logic [11:0]   bus_addr,
  input logic          bus_rd,
  input logic          bus_wr,
  input logic [31:0]   bus_wdata,
  input logic [31:0]   bus_rdata,
  input logic [31:0]   out_q,
  input logic [31:0]   dir_q,
  input logic [1023:0] cfg_q,
  input logic          bad_addr
);
  logic mapped;
  always_comb begin
    mapped = 1'b0;
    if (bus_addr[1:0] == 2'b00) begin
      if (bus_addr >= 12'h004 && bus_addr <= 12'h01C) mapped = 1'b1;
      if (bus_addr >= 12'h200 && bus_addr <= 12'h27C) mapped = 1'b1;
    end
  end

  a_r2_replace: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 12'h004) |=> out_q == $past(bus_wdata));
  a_r3_set: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 12'h008) |=> out_q == ($past(out_q) | $past(bus_wdata)));
  a_r4_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 12'h00C) |=> out_q == ($past(out_q) & ~$past(bus_wdata)));
  a_r6_dir_replace: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 12'h014) |=> dir_q == $past(bus_wdata));
  a_r7_cfg0_to_dir: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 12'h200) |=> (dir_q[0] == $past(bus_wdata[0])) && (cfg_q[31:0] == $past(bus_wdata)));
  a_r9_unmapped_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !mapped |-> bus_rdata == 32'h0);
  a_r9_unmapped_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && !mapped) |=> $stable(out_q) && $stable(dir_q) && $stable(cfg_q));
  a_r10_err_raise: assert property (@(posedge clk) disable iff (!rst_n)
    ((bus_rd || bus_wr) && !mapped) |=> bad_addr);
  a_r10_err_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !((bus_rd || bus_wr) && !mapped) |=> !bad_addr);
endmodule

bind gpio_setclr_bank gpio_setclr_bank_chk i_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .out_q(out_q), .dir_q(dir_q),
  .cfg_q(cfg_q), .bad_addr(bad_addr)
);

// File: tb/test_gpio_setclr_bank.sv
`timescale 1ns/1ps
module test_gpio_setclr_bank;
  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [11:0]   bus_addr = '0;
  logic          bus_rd = 1'b0, bus_wr = 1'b0;
  logic [31:0]   bus_wdata = '0, bus_rdata, pin_in = '0, out_q, dir_q;
  logic [1023:0] cfg_q;
  logic          bad_addr;

  int checks = 0, failures = 0;
  bit done = 0;
  logic [31:0] m_out = 0, m_dir = 0;
  logic [31:0] m_cfg [32];

  always #5 clk = ~clk;

  gpio_setclr_bank i_gpio_setclr_bank (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in), .out_q(out_q),
    .dir_q(dir_q), .cfg_q(cfg_q), .bad_addr(bad_addr));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic check_mirror(input string tag);
    logic ok = 1'b1;
    for (int i = 0; i < 32; i++) begin
      if (cfg_q[32*i] !== m_dir[i]) ok = 1'b0;
      if (cfg_q[32*i +: 32] !== m_cfg[i]) ok = 1'b0;
    end
    chk({tag, " cfg bit0 mirrors dir"}, {31'd0, ok}, 32'd1);
    chk({tag, " dir_q"}, dir_q, m_dir);
  endtask

  task automatic t_reset;
    logic [31:0] d;
    rd(12'h004, d); chk("R1 out reset", d, 0);
    rd(12'h014, d); chk("R1 dir reset", d, 0);
    rd(12'h010, d); chk("R1 in reset", d, 0);
    rd(12'h200, d); chk("R1 cfg0 reset", d, 32'h2);
    rd(12'h27C, d); chk("R1 cfg31 reset", d, 32'h2);
    check_mirror("R1");
  endtask

  task automatic t_out_ops;
    logic [31:0] d;
    wr(12'h004, 32'hF0F0_1234); m_out = 32'hF0F0_1234;
    chk("R2 replace out_q", out_q, m_out);
    wr(12'h004, 32'h0F0F_0001); m_out = 32'h0F0F_0001;
    chk("R2 replace again R11", out_q, m_out);
    wr(12'h008, 32'h8000_0F00); m_out |= 32'h8000_0F00;
    chk("R3 set", out_q, m_out);
    wr(12'h00C, 32'h0F00_0300); m_out &= ~32'h0F00_0300;
    chk("R4 clear", out_q, m_out);
    rd(12'h004, d); chk("R5 read out", d, m_out);
    rd(12'h008, d); chk("R5 read out set alias", d, m_out);
    rd(12'h00C, d); chk("R5 read out clr alias", d, m_out);
  endtask

  task automatic t_dir_ops;
    logic [31:0] d;
    wr(12'h014, 32'hA5A5_0F0F); m_dir = 32'hA5A5_0F0F;
    for (int i = 0; i < 32; i++) m_cfg[i][0] = m_dir[i];
    check_mirror("R6 replace");
    wr(12'h018, 32'h00F0_00F0); m_dir |= 32'h00F0_00F0;
    for (int i = 0; i < 32; i++) m_cfg[i][0] = m_dir[i];
    check_mirror("R6 set");
    wr(12'h01C, 32'h8000_0F01); m_dir &= ~32'h8000_0F01;
    for (int i = 0; i < 32; i++) m_cfg[i][0] = m_dir[i];
    check_mirror("R6 clear");
    rd(12'h014, d); chk("R5 read dir", d, m_dir);
    rd(12'h018, d); chk("R5 read dir set alias", d, m_dir);
    rd(12'h01C, d); chk("R5 read dir clr alias", d, m_dir);
    chk("R6 out untouched", out_q, m_out);
  endtask

  task automatic t_cfg;
    logic [31:0] d;
    wr(12'h21C, 32'hDEAD_BEE1); m_cfg[7] = 32'hDEAD_BEE1; m_dir[7] = 1'b1;
    rd(12'h21C, d); chk("R7 cfg7 read", d, 32'hDEAD_BEE1);
    check_mirror("R7 set pin7");
    wr(12'h27C, 32'h1234_5670); m_cfg[31] = 32'h1234_5670; m_dir[31] = 1'b0;
    check_mirror("R7 pin31 low");
    wr(12'h200, 32'h0000_000D); m_cfg[0] = 32'h0000_000D; m_dir[0] = 1'b1;
    check_mirror("R7 pin0");
    wr(12'h21C, 32'h0000_000C); m_cfg[7] = 32'h0000_000C; m_dir[7] = 1'b0;
    check_mirror("R7 clear pin7 R11");
    rd(12'h014, d); chk("R7 dir read", d, m_dir);
  endtask

  task automatic t_input;
    logic [31:0] d;
    @(negedge clk); pin_in = 32'h1234_5678;
    rd(12'h010, d); chk("R8 input", d, 32'h1234_5678);
    wr(12'h010, 32'hFFFF_FFFF);
    rd(12'h010, d); chk("R8 write ignored in", d, 32'h1234_5678);
    chk("R8 write ignored out", out_q, m_out);
    chk("R8 write ignored dir", dir_q, m_dir);
    @(negedge clk); pin_in = 32'hCAFE_0001;
    rd(12'h010, d); chk("R8 input change", d, 32'hCAFE_0001);
  endtask

  task automatic t_unmapped;
    logic [31:0] d;
    logic [11:0] bad [5] = '{12'h000, 12'h020, 12'h006, 12'h280, 12'h201};
    for (int k = 0; k < 5; k++) begin
      rd(bad[k], d);
      chk($sformatf("R9 read %h zero", bad[k]), d, 0);
      chk($sformatf("R10 err after read %h", bad[k]), {31'd0, bad_addr}, 1);
    end
    @(negedge clk);
    chk("R10 err drops", {31'd0, bad_addr}, 0);
    wr(12'h280, 32'hFFFF_FFFF);
    chk("R10 err after write", {31'd0, bad_addr}, 1);
    chk("R9 write ignored out", out_q, m_out);
    check_mirror("R9 write ignored");
    wr(12'h007, 32'hFFFF_FFFF);
    chk("R9 misaligned write ignored", out_q, m_out);
    rd(12'h004, d);
    chk("R10 no err on mapped", {31'd0, bad_addr}, 0);
  endtask

  initial begin
    for (int i = 0; i < 32; i++) m_cfg[i] = 32'h2;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_out_ops();
    t_dir_ops();
    t_cfg();
    t_input();
    t_unmapped();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    #200000;
    if (!done) begin
      done = 1;
      checks++; failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule